// File: doc/BRIEF.md
# DC Offset Successive-Approximation Calibration Controller

This block settles the DC offset of the I and Q baseband paths of a receiver. It owns two 8-bit correction DAC codes. It adjusts them with a successive-approximation search, one code per channel. The offset detector is reduced to one sign bit per channel. A sign of 1 tells the search to keep the bit under trial; a sign of 0 tells it to clear that bit. Both channels are searched at the same time, and each follows its own sign.

The search advances on a calibration tick. The tick is made from one of two clock-enable sources, either the internal oscillator or the serial-port clock, passed through a divider whose ratio is picked by a 3-bit code. The search starts when a start bit is written while automatic mode and binary search are both enabled. It finishes on the ninth tick, and the start bit then clears itself. The resulting codes are held until another search starts or a calibration reset is applied. When automatic mode and binary search are both off, the DAC codes come straight from the manually programmed values.

Top module: `offsetSarCal`

## Requirements
- R1: After power-on reset, with automatic mode on, both code outputs read 128 (0x80), and `busy`, `done` and `startPending` are all 0.
- R2: A pulse on `startSet` starts a search only when `autoMode` and `searchEn` are both 1. With either of them at 0, the pulse is ignored: `busy` and `startPending` stay 0 and the codes do not change.
- R3: A search loads both codes to 0x80 and then tests bits from bit 7 down to bit 0, one bit per tick. On each tick, the bit under trial is kept if that channel's sign is 1 and cleared if it is 0, and the next lower bit is set. With a sign that is 1 exactly when the code is not above a target, the search ends on that target, for each channel on its own.
- R4: The search ends on the ninth tick. `busy` is high from the cycle after the start until that tick. `done` pulses for exactly one cycle, and `startPending` falls as `done` rises. With the selected source enabled in every cycle, `busy` lasts 9 x ratio cycles.
- R5: After a search, the codes are held unchanged until a new search or a calibration reset. A `startSet` pulse during a search neither restarts nor lengthens it.
- R6: When `autoMode` and `searchEn` are both 0, `codeI` and `codeQ` follow `manI` and `manQ` directly. Returning to automatic mode shows the held search result again.
- R7: With `clkSrcSel` at 1, the search counts `oscTick` enables. With `clkSrcSel` at 0, it counts `serTick` enables. Enables from the source that is not selected have no effect.
- R8: `divSel` codes 0 to 7 give one tick per 1, 8, 16, 128, 256, 1024, 2048 and 16384 enables of the selected source.
- R9: `calReset` reloads both codes to 128, aborts a search in progress (`busy` and `startPending` go to 0 on the next cycle), and wins over a `startSet` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calReset | input | 1 | Calibration reset: reload midscale, abort search |
| startSet | input | 1 | Write pulse of the start bit |
| autoMode | input | 1 | Automatic correction mode |
| searchEn | input | 1 | Binary-search enable |
| clkSrcSel | input | 1 | 1 selects the oscillator enable, 0 the serial-clock enable |
| oscTick | input | 1 | Internal oscillator clock enable |
| serTick | input | 1 | Serial clock enable |
| divSel | input | 3 | Divider ratio code |
| signI | input | 1 | I-channel detector sign (1 = keep bit) |
| signQ | input | 1 | Q-channel detector sign (1 = keep bit) |
| manI | input | 8 | Manual I correction code |
| manQ | input | 8 | Manual Q correction code |
| codeI | output | 8 | I correction DAC code |
| codeQ | output | 8 | Q correction DAC code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| startPending | output | 1 | Read-back of the self-clearing start bit |

## Verification
The bench drives targets at the extremes 0 and 255, and the I and Q targets point in opposite directions. A design that tested the bits in the wrong order, or shared one sign between the channels, would converge on the wrong code. Every divider code from 0 to 6 is timed by counting busy cycles, and code 7 is checked by watching the first bit decision land exactly after 16384 enables. A wrong table entry or an off-by-one terminal count would shift these. The bench pulses a start mid-search, starts with one of the two mode bits off, and runs with the other clock source toggling. A design that restarted, started without permission, or counted the wrong source would show an extra or missing busy cycle or a moved code. A calibration reset that arrives together with a start must leave the block idle at midscale.

// File: rtl/offsetSarCalPkg.sv
package offsetSarCalPkg;

  localparam int DIVSEL_W = 3;

  typedef enum logic {
    CAL_IDLE   = 1'b0,
    CAL_SEARCH = 1'b1
  } calStateT;

  // strobes from the search control into the code datapath
  typedef struct packed {
    logic loadMid;      // force midscale (calibration reset)
    logic beginSearch;  // load the first trial code
    logic stepBit;      // resolve the bit under trial, arm the next one
  } sarStrobeT;

endpackage

// File: rtl/calTickGen.sv
module calTickGen
  import offsetSarCalPkg::*;
#(
  parameter int DIV_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic                clkSrcSel,
  input  logic                oscTick,
  input  logic                serTick,
  input  logic [DIVSEL_W-1:0] divSel,
  output logic                calTick
);

  logic             srcEn;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] termCnt;
  logic [4:0]       shiftAmt;
  logic [DIV_W:0]   ratio;

  // ratio = 2**shiftAmt; table of power-of-two ratios
  always_comb begin
    case (divSel)
      3'd0:    shiftAmt = 5'd0;
      3'd1:    shiftAmt = 5'd3;
      3'd2:    shiftAmt = 5'd4;
      3'd3:    shiftAmt = 5'd7;
      3'd4:    shiftAmt = 5'd8;
      3'd5:    shiftAmt = 5'd10;
      3'd6:    shiftAmt = 5'd11;
      default: shiftAmt = 5'd14;
    endcase
    ratio   = (DIV_W + 1)'(1) << shiftAmt;
    termCnt = DIV_W'(ratio - (DIV_W + 1)'(1));
  end

  assign srcEn   = clkSrcSel ? oscTick : serTick;
  assign calTick = run && srcEn && (divCnt == termCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!run) begin
      divCnt <= '0;
    end else if (srcEn) begin
      divCnt <= (divCnt == termCnt) ? '0 : divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sarCtrl.sv
module sarCtrl
  import offsetSarCalPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calReset,
  input  logic              startSet,
  input  logic              autoOk,
  input  logic              calTick,
  output sarStrobeT         strobe,
  output logic [CODE_W-1:0] trialMask,
  output logic              busy,
  output logic              done,
  output logic              startPending
);

  localparam int                CNT_W     = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(CODE_W);
  localparam logic [CODE_W-1:0] TOP_BIT   = {1'b1, {(CODE_W-1){1'b0}}};

  calStateT         state;
  logic [CNT_W-1:0] stepCnt;
  logic             finishNow;

  always_comb begin
    strobe    = '0;
    finishNow = 1'b0;
    if (calReset) begin
      strobe.loadMid = 1'b1;
    end else if (state == CAL_IDLE) begin
      if (startSet && autoOk) strobe.beginSearch = 1'b1;
    end else if (calTick) begin
      if (stepCnt == LAST_STEP) finishNow = 1'b1;
      else                      strobe.stepBit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= CAL_IDLE;
      stepCnt      <= '0;
      trialMask    <= '0;
      done         <= 1'b0;
      startPending <= 1'b0;
    end else begin
      done <= finishNow;
      if (strobe.loadMid) begin
        state        <= CAL_IDLE;
        stepCnt      <= '0;
        trialMask    <= '0;
        startPending <= 1'b0;
      end else if (strobe.beginSearch) begin
        state        <= CAL_SEARCH;
        stepCnt      <= '0;
        trialMask    <= TOP_BIT;
        startPending <= 1'b1;
      end else if (strobe.stepBit) begin
        stepCnt   <= stepCnt + 1'b1;
        trialMask <= trialMask >> 1;
      end else if (finishNow) begin
        state        <= CAL_IDLE;
        startPending <= 1'b0;
      end
    end
  end

  assign busy = (state == CAL_SEARCH);

endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import offsetSarCalPkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NCH    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sarStrobeT             strobe,
  input  logic [CODE_W-1:0]     trialMask,
  input  logic [NCH-1:0]        signIn,
  output logic [NCH*CODE_W-1:0] codeOut
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CODE_W-1:0] codeReg;
    logic [CODE_W-1:0] resolved;

    // keep or drop the bit under trial, then arm the next lower bit
    assign resolved = signIn[ch] ? codeReg : (codeReg & ~trialMask);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeReg <= MID;
      end else if (strobe.loadMid || strobe.beginSearch) begin
        codeReg <= MID;
      end else if (strobe.stepBit) begin
        codeReg <= resolved | (trialMask >> 1);
      end
    end

    assign codeOut[ch*CODE_W +: CODE_W] = codeReg;
  end

endmodule

// File: rtl/offsetSarCal.sv
module offsetSarCal
  import offsetSarCalPkg::*;
#(
  parameter int CODE_W = 8,
  parameter int DIV_W  = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                calReset,
  input  logic                startSet,
  input  logic                autoMode,
  input  logic                searchEn,
  input  logic                clkSrcSel,
  input  logic                oscTick,
  input  logic                serTick,
  input  logic [DIVSEL_W-1:0] divSel,
  input  logic                signI,
  input  logic                signQ,
  input  logic [CODE_W-1:0]   manI,
  input  logic [CODE_W-1:0]   manQ,
  output logic [CODE_W-1:0]   codeI,
  output logic [CODE_W-1:0]   codeQ,
  output logic                busy,
  output logic                done,
  output logic                startPending
);

  localparam int NCH = 2;

  sarStrobeT           strobe;
  logic [CODE_W-1:0]   trialMask;
  logic                calTick;
  logic [NCH*CODE_W-1:0] heldCodes;
  logic [CODE_W-1:0]   heldI;
  logic [CODE_W-1:0]   heldQ;
  logic                autoOk;
  logic                manualSel;

  assign autoOk    = autoMode && searchEn;
  assign manualSel = !autoMode && !searchEn;

  calTickGen #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rstN      (rstN),
    .run       (busy),
    .clkSrcSel (clkSrcSel),
    .oscTick   (oscTick),
    .serTick   (serTick),
    .divSel    (divSel),
    .calTick   (calTick)
  );

  sarCtrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .calReset     (calReset),
    .startSet     (startSet),
    .autoOk       (autoOk),
    .calTick      (calTick),
    .strobe       (strobe),
    .trialMask    (trialMask),
    .busy         (busy),
    .done         (done),
    .startPending (startPending)
  );

  sarDatapath #(.CODE_W(CODE_W), .NCH(NCH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .trialMask (trialMask),
    .signIn    ({signQ, signI}),
    .codeOut   (heldCodes)
  );

  assign heldI = heldCodes[0 +: CODE_W];
  assign heldQ = heldCodes[CODE_W +: CODE_W];

  assign codeI = manualSel ? manI : heldI;
  assign codeQ = manualSel ? manQ : heldQ;

endmodule

// File: rtl/offsetSarCalChk.sv
module offsetSarCalChk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              calReset,
  input logic              startSet,
  input logic              autoMode,
  input logic              searchEn,
  input logic              busy,
  input logic              done,
  input logic              startPending,
  input logic [CODE_W-1:0] heldI,
  input logic [CODE_W-1:0] heldQ
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  AST_RESET_TO_MID: assert property (@(posedge clk) disable iff (!rstN)
    calReset |=> (heldI == MID && heldQ == MID && !busy && !startPending)); // R9

  AST_NO_START_WITHOUT_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(autoMode && searchEn)) |=> !busy); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4

  AST_DONE_ENDS_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R4

  AST_START_BIT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !startPending); // R4

  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> startPending); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !calReset && !startSet) |=> ($stable(heldI) && $stable(heldQ))); // R5

endmodule

bind offsetSarCal offsetSarCalChk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .calReset     (calReset),
  .startSet     (startSet),
  .autoMode     (autoMode),
  .searchEn     (searchEn),
  .busy         (busy),
  .done         (done),
  .startPending (startPending),
  .heldI        (heldI),
  .heldQ        (heldQ)
);

// File: tb/sim_offsetSarCal.sv
module sim_offsetSarCal;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  typedef struct {
    logic [7:0] expI;
    logic [7:0] expQ;
    int         expCycles;
  } expItemT;

  logic       clk = 1'b0;
  logic       rstN, calReset, startSet, autoMode, searchEn, clkSrcSel;
  logic       oscTick, serTick, signI, signQ;
  logic [2:0] divSel;
  logic [7:0] manI, manQ, codeI, codeQ, tgtI, tgtQ;
  logic       busy, done, startPending;

  int nChecks = 0, nFails = 0, monChecks = 0, monFails = 0, busyCnt = 0;
  expItemT sbQueue[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // detector model: keep the trial bit while the code is not above target
  assign signI = (codeI <= tgtI);
  assign signQ = (codeQ <= tgtQ);

  offsetSarCal u0 (
    .clk(clk), .rstN(rstN), .calReset(calReset), .startSet(startSet),
    .autoMode(autoMode), .searchEn(searchEn), .clkSrcSel(clkSrcSel),
    .oscTick(oscTick), .serTick(serTick), .divSel(divSel),
    .signI(signI), .signQ(signQ), .manI(manI), .manQ(manQ),
    .codeI(codeI), .codeQ(codeQ), .busy(busy), .done(done),
    .startPending(startPending)
  );

  function automatic int ratioOf(input int code);
    int tbl[8] = '{1, 8, 16, 128, 256, 1024, 2048, 16384};
    return tbl[code];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each finished search against the queue
  always @(negedge clk) begin
    if (done) begin
      if (sbQueue.size() > 0) begin
        expItemT it;
        it = sbQueue.pop_front();
        monChecks += 3;
        if (codeI != it.expI) begin
          monFails++;
          $display("FAIL R3 codeI actual=%0d expected=%0d", codeI, it.expI);
        end
        if (codeQ != it.expQ) begin
          monFails++;
          $display("FAIL R3 codeQ actual=%0d expected=%0d", codeQ, it.expQ);
        end
        if (busyCnt != it.expCycles) begin
          monFails++;
          $display("FAIL R4/R8 busy cycles actual=%0d expected=%0d", busyCnt, it.expCycles);
        end
      end
      busyCnt = 0;
    end else if (busy) begin
      busyCnt = busyCnt + 1;
    end else begin
      busyCnt = 0;
    end
  end

  task automatic runCal(input logic [7:0] tI, input logic [7:0] tQ, input int d,
                        input bit extraStart);
    expItemT it;
    tgtI   = tI;
    tgtQ   = tQ;
    divSel = 3'(d);
    it.expI = tI;
    it.expQ = tQ;
    it.expCycles = 9 * ratioOf(d);
    sbQueue.push_back(it);
    startSet = 1'b1;
    @(negedge clk);
    startSet = 1'b0;
    if (extraStart) begin
      repeat (5) @(negedge clk);
      startSet = 1'b1;   // R5: must not restart the search
      @(negedge clk);
      startSet = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", (nChecks + monChecks) - (nFails + monFails),
             nChecks + monChecks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; calReset = 1'b0; startSet = 1'b0;
    autoMode = 1'b1; searchEn = 1'b1; clkSrcSel = 1'b1;
    oscTick = 1'b1; serTick = 1'b0; divSel = 3'd0;
    manI = 8'h00; manQ = 8'h00; tgtI = 8'h00; tgtQ = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(codeI == 8'd128, "R1 codeI", codeI, 128);
    chk(codeQ == 8'd128, "R1 codeQ", codeQ, 128);
    chk(!busy && !done && !startPending, "R1 flags", {busy, done, startPending}, 0);

    // R3 R4 R8 scoreboard runs across divider codes 0..6
    runCal(8'h5A, 8'hC3, 0, 1'b0);
    runCal(8'h00, 8'hFF, 0, 1'b0);
    runCal(8'hFF, 8'h00, 1, 1'b0);
    runCal(8'h7F, 8'h80, 2, 1'b0);
    for (int d = 3; d < 7; d++) runCal(8'((37 * d + 11) & 255), 8'((91 * d + 5) & 255), d, 1'b0);

    // R5 start during a search is ignored (scoreboard checks length), then hold
    runCal(8'h3C, 8'hA5, 1, 1'b1);
    repeat (20) @(negedge clk);
    chk(codeI == 8'h3C, "R5 hold codeI", codeI, 8'h3C);
    chk(codeQ == 8'hA5, "R5 hold codeQ", codeQ, 8'hA5);

    // R2 start ignored without both mode bits
    autoMode = 1'b0; searchEn = 1'b1; tgtI = 8'h01;
    startSet = 1'b1; @(negedge clk); startSet = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !startPending, "R2 autoMode=0", {busy, startPending}, 0);
    chk(codeI == 8'h3C, "R2 code kept", codeI, 8'h3C);
    autoMode = 1'b1; searchEn = 1'b0;
    startSet = 1'b1; @(negedge clk); startSet = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !startPending, "R2 searchEn=0", {busy, startPending}, 0);

    // R6 manual mode
    autoMode = 1'b0; searchEn = 1'b0; manI = 8'h12; manQ = 8'hEF;
    @(negedge clk);
    chk(codeI == 8'h12 && codeQ == 8'hEF, "R6 manual", {codeI, codeQ}, 16'h12EF);
    manI = 8'h34;
    @(negedge clk);
    chk(codeI == 8'h34, "R6 manual tracks", codeI, 8'h34);
    autoMode = 1'b1; searchEn = 1'b1;
    @(negedge clk);
    chk(codeI == 8'h3C && codeQ == 8'hA5, "R6 back to held", {codeI, codeQ}, 16'h3CA5);

    // R7 clock source select: oscillator toggling while serial selected
    clkSrcSel = 1'b0; oscTick = 1'b1; serTick = 1'b0;
    tgtI = 8'h66; tgtQ = 8'h99; divSel = 3'd0;
    startSet = 1'b1; @(negedge clk); startSet = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R7 still busy", busy, 1);
    chk(codeI == 8'h80, "R7 no step from unselected source", codeI, 8'h80);
    serTick = 1'b1; oscTick = 1'b0;
    do @(negedge clk); while (!done);
    chk(codeI == 8'h66 && codeQ == 8'h99, "R7 serial result", {codeI, codeQ}, 16'h6699);
    clkSrcSel = 1'b1; oscTick = 1'b1; serTick = 1'b0;
    @(negedge clk);

    // R8 divider code 7: first decision after exactly 16384 enables
    tgtI = 8'h10; tgtQ = 8'hF0; divSel = 3'd7;
    startSet = 1'b1; @(negedge clk); startSet = 1'b0;   // busy cycle 1
    repeat (16382) @(negedge clk);                       // busy cycle 16383
    chk(codeI == 8'h80, "R8 code7 before tick", codeI, 8'h80);
    @(negedge clk);                                      // busy cycle 16384
    chk(codeI == 8'h80, "R8 code7 tick cycle", codeI, 8'h80);
    @(negedge clk);                                      // first step visible
    chk(codeI == 8'h40 && codeQ == 8'hC0, "R8 code7 first step", {codeI, codeQ}, 16'h40C0);

    // R9 calibration reset aborts the search
    calReset = 1'b1; @(negedge clk); calReset = 1'b0;
    chk(!busy && !startPending, "R9 abort", {busy, startPending}, 0);
    chk(codeI == 8'd128 && codeQ == 8'd128, "R9 midscale", {codeI, codeQ}, 16'h8080);
    divSel = 3'd0;
    calReset = 1'b1; startSet = 1'b1; @(negedge clk);
    calReset = 1'b0; startSet = 1'b0;
    chk(!busy && !startPending, "R9 reset beats start", {busy, startPending}, 0);
    repeat (3) @(negedge clk);
    chk(codeI == 8'd128 && !done, "R9 stays idle", codeI, 128);

    // R3 recovery run after reset
    runCal(8'hB7, 8'h2E, 0, 1'b0);
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end

endmodule